// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is a single DMA channel that follows a linked list of descriptors kept in system memory. Each descriptor occupies three consecutive 32-bit words: a buffer base address, a control word that combines a byte count with flags, and the address of the following descriptor. For every descriptor the channel reads the three words, then moves the requested number of bytes between the buffer and a byte stream on the device side. In transmit mode bytes flow from memory to the device. In receive mode they flow from the device to memory. When the buffer is finished, the channel writes the control word back with a completion mark, raises an interrupt if the descriptor asked for one, and either moves on to the next descriptor or stops.

Software sees two registers. The control/status register starts, stops and sets the direction of the channel, and reports the interrupt and busy flags. The pointer register holds the address of the descriptor to be processed next. Memory is reached through a simple port that keeps one request open until it is acknowledged. Descriptor words use little-endian byte order. Data bytes are single-byte accesses.

Top module: `dma_chain_top`

## Requirements
- R1: A descriptor is fetched as three word reads at pointer, pointer+4 and pointer+8, in that order, and descriptors are processed in chain order.
- R2: Bits 13:0 of the control word give the byte count N. The bytes at buffer+0 through buffer+N-1 are transferred in ascending order, and the byte at buffer+N is not touched.
- R3: In transmit mode (ctrl bit 2 = 0) each byte is offered with tx_valid and is held until tx_ready. tx_last is high only on the final byte of a descriptor whose bit 30 is set.
- R4: In receive mode (ctrl bit 2 = 1) device bytes are taken when rx_valid and rx_ready are both high, and are written to the buffer. A descriptor whose bit 14 (owned) is clear halts the channel before any transfer. In that case nothing is written, no interrupt is raised, and the pointer still names that descriptor.
- R5: After the data of a descriptor has moved, its control word is written back to pointer+4. A transmit write-back sets bit 15. A receive write-back clears bit 14. All other bits are kept.
- R6: After each descriptor the pointer register takes the next-descriptor word. When bit 31 is set the channel stops and its busy flag clears.
- R7: Control word bit 29 sets the interrupt flag (irq output, status bit 0) when the descriptor completes. A read of the status register clears the flag. When a completion and a status read occur in the same cycle, the flag is set.
- R8: A control write (reg_sel = 0) changes the run state only when bit 5 is 1. The channel is then set running if bit 4 is 1 and stopped at once if bit 4 is 0. Status bit 1 reports the run state.
- R9: A descriptor with a count of zero moves no data. Its write-back, interrupt and end-of-chain flags are still honoured.
- R10: Software may write the pointer register (reg_sel = 1) only while the channel is stopped. Writes made while it is running are ignored.
- R11: A memory request keeps its address and type stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears the interrupt) |
| reg_sel | input | 1 | 0 = control/status, 1 = descriptor pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_byte | output | 1 | Byte access (data in bits 7:0); otherwise a word |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Byte ends a packet |
| tx_ready | input | 1 | Device accepts the transmit byte |
| rx_valid | input | 1 | Receive byte available |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Channel accepts the receive byte |
| irq | output | 1 | Interrupt flag |

## Verification
Two things can land in the same clock cycle: a descriptor completing with its interrupt request, and a software read of the status register that clears the interrupt flag. The bench forces this overlap by holding the status read strobe high for a whole chain run, so some read always coincides with the completion cycle. It then requires the flag to be seen high for exactly one cycle: the set must win in the overlap cycle, and the read in the following cycle must clear it. Transmit runs sweep buffer length, memory latency and device back-pressure. Expected byte streams and write-back words are computed from the buffer addresses.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 14;
    localparam int BYTE_W = 8;

    // control word flag positions
    localparam int F_EOC  = 31;
    localparam int F_EOP  = 30;
    localparam int F_IRQ  = 29;
    localparam int F_DONE = 15;
    localparam int F_OWN  = 14;

    // control register write bits
    localparam int C_RX = 2;
    localparam int C_GO = 4;
    localparam int C_LD = 5;

    typedef enum logic [3:0] {
        S_IDLE, S_D0, S_D1, S_D2, S_CHK,
        S_MRD, S_PUSH, S_POP, S_MWR, S_WB, S_FIN
    } eng_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] bptr;
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] next;
    } desc_t;

    function automatic logic [WORD_W-1:0] wb_word(input logic [WORD_W-1:0] ctl,
                                                  input logic rx);
        if (rx) return ctl & ~(WORD_W'(1) << F_OWN);
        return ctl | (WORD_W'(1) << F_DONE);
    endfunction
endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              halt,
    input  logic              irq_set,
    input  logic              ptr_we,
    input  logic [WORD_W-1:0] ptr_nxt,
    output logic              active,
    output logic              rx_mode,
    output logic              irq,
    output logic [WORD_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            rx_mode <= 1'b0;
            irq     <= 1'b0;
            ptr     <= '0;
        end else begin
            if (reg_wr && !reg_sel && reg_wdata[C_LD]) begin
                active  <= reg_wdata[C_GO];
                rx_mode <= reg_wdata[C_RX];
            end else if (halt) begin
                active <= 1'b0;
            end

            if (irq_set)
                irq <= 1'b1;
            else if (reg_rd && !reg_sel)
                irq <= 1'b0;

            if (ptr_we)
                ptr <= ptr_nxt;
            else if (reg_wr && reg_sel && !active)
                ptr <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = reg_sel ? ptr : {{(WORD_W-2){1'b0}}, active, irq};
    end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rx_mode,
    input  logic [WORD_W-1:0] ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              halt,
    output logic              irq_set,
    output logic              ptr_we,
    output logic [WORD_W-1:0] ptr_nxt
);
    eng_state_e        st;
    desc_t             d;
    logic [LEN_W-1:0]  idx;
    logic [BYTE_W-1:0] data_q;
    logic [LEN_W-1:0]  len;
    logic              last;
    logic [WORD_W-1:0] byte_addr;

    assign len       = d.ctl[LEN_W-1:0];
    assign last      = (idx == len - 1'b1);
    assign byte_addr = d.bptr + {{(WORD_W-LEN_W){1'b0}}, idx};

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            d      <= '0;
            idx    <= '0;
            data_q <= '0;
        end else if (!active) begin
            st <= S_IDLE;
        end else begin
            case (st)
                S_IDLE: st <= S_D0;
                S_D0: if (mem_ack) begin d.bptr <= mem_rdata; st <= S_D1; end
                S_D1: if (mem_ack) begin d.ctl  <= mem_rdata; st <= S_D2; end
                S_D2: if (mem_ack) begin d.next <= mem_rdata; st <= S_CHK; end
                S_CHK: begin
                    idx <= '0;
                    if (rx_mode && !d.ctl[F_OWN]) st <= S_IDLE;
                    else if (len == '0)           st <= S_WB;
                    else if (rx_mode)             st <= S_POP;
                    else                          st <= S_MRD;
                end
                S_MRD: if (mem_ack) begin
                    data_q <= mem_rdata[BYTE_W-1:0];
                    st     <= S_PUSH;
                end
                S_PUSH: if (tx_ready) begin
                    idx <= idx + 1'b1;
                    st  <= last ? S_WB : S_MRD;
                end
                S_POP: if (rx_valid) begin
                    data_q <= rx_data;
                    st     <= S_MWR;
                end
                S_MWR: if (mem_ack) begin
                    idx <= idx + 1'b1;
                    st  <= last ? S_WB : S_POP;
                end
                S_WB:  if (mem_ack) st <= S_FIN;
                S_FIN: st <= d.ctl[F_EOC] ? S_IDLE : S_D0;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_byte  = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        case (st)
            S_D0: mem_req = 1'b1;
            S_D1: begin mem_req = 1'b1; mem_addr = ptr + WORD_W'(4); end
            S_D2: begin mem_req = 1'b1; mem_addr = ptr + WORD_W'(8); end
            S_MRD: begin
                mem_req  = 1'b1;
                mem_byte = 1'b1;
                mem_addr = byte_addr;
            end
            S_MWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_byte  = 1'b1;
                mem_addr  = byte_addr;
                mem_wdata = {{(WORD_W-BYTE_W){1'b0}}, data_q};
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + WORD_W'(4);
                mem_wdata = wb_word(d.ctl, rx_mode);
            end
            default: ;
        endcase
    end

    assign tx_valid = (st == S_PUSH);
    assign tx_data  = data_q;
    assign tx_last  = (st == S_PUSH) && last && d.ctl[F_EOP];
    assign rx_ready = (st == S_POP);
    assign halt     = ((st == S_CHK) && rx_mode && !d.ctl[F_OWN])
                   || ((st == S_FIN) && d.ctl[F_EOC]);
    assign irq_set  = (st == S_FIN) && d.ctl[F_IRQ];
    assign ptr_we   = (st == S_FIN);
    assign ptr_nxt  = d.next;
endmodule

// File: rtl/dma_chain_top.sv
module dma_chain_top
    import dma_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              irq
);
    logic              active_w;
    logic              rx_mode_w;
    logic              halt_w;
    logic              irq_set_w;
    logic              ptr_we_w;
    logic [WORD_W-1:0] ptr_w;
    logic [WORD_W-1:0] ptr_nxt_w;

    dma_chain_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .halt     (halt_w),
        .irq_set  (irq_set_w),
        .ptr_we   (ptr_we_w),
        .ptr_nxt  (ptr_nxt_w),
        .active   (active_w),
        .rx_mode  (rx_mode_w),
        .irq      (irq),
        .ptr      (ptr_w)
    );

    dma_chain_engine eng_i (
        .clk      (clk),
        .rst      (rst),
        .active   (active_w),
        .rx_mode  (rx_mode_w),
        .ptr      (ptr_w),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_byte (mem_byte),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .halt     (halt_w),
        .irq_set  (irq_set_w),
        .ptr_we   (ptr_we_w),
        .ptr_nxt  (ptr_nxt_w)
    );
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk
    import dma_chain_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              reg_sel,
    input logic [WORD_W-1:0] reg_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [WORD_W-1:0] mem_addr,
    input logic              tx_valid,
    input logic              tx_last,
    input logic              rx_ready,
    input logic              irq,
    input logic              active,
    input logic              irq_set
);
    logic ld_wr;
    assign ld_wr = reg_wr && !reg_sel && reg_wdata[C_LD];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !ld_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

    AST_START_NEEDS_LD: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(ld_wr && reg_wdata[C_GO])); // R8

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> irq); // R7

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_sel && !irq_set) |=> !irq); // R7

    AST_EOP_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid); // R3

    AST_DIR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && rx_ready)); // R4

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!active && $past(!active)) |-> !mem_req); // R6
endmodule

bind dma_chain_top dma_chain_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .rx_ready (rx_ready),
    .irq      (irq),
    .active   (active_w),
    .irq_set  (irq_set_w)
);

// File: tb/dma_chain_tb.sv
module dma_chain_top_tb_top;
    localparam logic [31:0] EOC = 32'h8000_0000;
    localparam logic [31:0] EOP = 32'h4000_0000;
    localparam logic [31:0] IRQ = 32'h2000_0000;
    localparam logic [31:0] DON = 32'h0000_8000;
    localparam logic [31:0] OWN = 32'h0000_4000;
    localparam logic [31:0] GO_TX = 32'h30;
    localparam logic [31:0] GO_RX = 32'h34;

    logic clk = 0, rst = 1;
    logic reg_wr = 0, reg_rd = 0, reg_sel = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mem_req, mem_we, mem_byte, mem_ack = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic tx_valid, tx_last, tx_ready = 0, rx_valid = 0, rx_ready, irq;
    logic [7:0] tx_data, rx_data = 0;

    always #2.5 clk = ~clk;

    dma_chain_top dut_i (.*);

    int errs = 0, checks = 0;
    logic [7:0] mem [0:1023];
    int lat = 0, wcnt = 0, rdy_mode = 0;
    logic [31:0] rd_log [0:63];
    int rd_n = 0;
    logic [7:0] cap_d [0:63];
    logic cap_l [0:63];
    int cap_n = 0;
    int rx_idx = 0, rx_total = 0;
    bit rx_took = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rw(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic pw(input int a, input logic [31:0] v);
        mem[a] = v[7:0]; mem[a+1] = v[15:8]; mem[a+2] = v[23:16]; mem[a+3] = v[31:24];
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    // memory model
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 0;
            wcnt = lat;
        end else if (mem_req) begin
            if (wcnt <= 0) begin
                mem_ack = 1;
                if (mem_we) begin
                    if (mem_byte) mem[mem_addr[9:0]] = mem_wdata[7:0];
                    else pw(int'(mem_addr[9:0]), mem_wdata);
                end else begin
                    mem_rdata = mem_byte ? {24'h0, mem[mem_addr[9:0]]} : rw(int'(mem_addr[9:0]));
                    if (!mem_byte && rd_n < 64) begin rd_log[rd_n] = mem_addr; rd_n++; end
                end
            end else wcnt--;
        end else wcnt = lat;
    end

    // transmit sink
    always @(negedge clk) begin
        case (rdy_mode)
            0: tx_ready = 1;
            1: tx_ready = ~tx_ready;
            default: tx_ready = 0;
        endcase
        if (tx_valid && tx_ready && cap_n < 64) begin
            cap_d[cap_n] = tx_data; cap_l[cap_n] = tx_last; cap_n++;
        end
    end

    // receive source
    always @(negedge clk) begin
        if (rx_took) begin rx_idx++; rx_took = 0; end
        rx_valid = (rx_idx < rx_total);
        rx_data = 8'(8'hA0 + rx_idx);
        if (rx_valid && rx_ready) rx_took = 1;
    end

    task automatic wr_reg(input logic sel, input logic [31:0] v);
        @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] v);
        @(negedge clk); reg_rd = 1; reg_sel = sel; #1 v = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit ok;
        int seen, seen_rd;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h55;
        repeat (4) @(negedge clk);
        rst = 0;
        #1;
        check(reg_rdata == 0 && !mem_req && !irq && !tx_valid, "R8 reset", reg_rdata, 0);

        // start without load enable (R8)
        wr_reg(1, 32'h40);
        wr_reg(0, 32'h10);
        ok = 1;
        repeat (20) @(negedge clk) if (mem_req) ok = 0;
        check(ok, "R8 start ignored without load-enable", {31'h0, ok}, 1);
        rd_reg(0, v);
        check(v == 0, "R8 status stays idle", v, 0);

        // single-descriptor transmit sweep (R2 R3 R5 R6 R7 R9 R10)
        for (int len = 0; len < 7; len++) begin
            for (int l = 0; l < 3; l++) begin
                logic [31:0] ctl;
                lat = l; rdy_mode = l % 2; cap_n = 0;
                for (int i = 0; i < 8; i++) mem[256 + i] = pat(256 + i);
                ctl = EOC | EOP | ((len % 2) ? IRQ : 0) | 32'(len);
                pw(64, 32'h100); pw(68, ctl); pw(72, 32'h80 + 32'(len));
                wr_reg(1, 32'h40);
                wr_reg(0, GO_TX);
                repeat (400) @(negedge clk);
                ok = (cap_n == len);
                for (int i = 0; i < cap_n; i++)
                    if (cap_d[i] != pat(256 + i) || cap_l[i] != (i == len - 1)) ok = 0;
                check(ok, "R2 R3 byte stream and packet end", 32'(cap_n), 32'(len));
                check(rw(68) == (ctl | DON), "R5 transmit write-back", rw(68), ctl | DON);
                check(irq == (len % 2), "R7 irq from descriptor flag", {31'h0, irq}, 32'(len % 2));
                rd_reg(1, v);
                check(v == 32'h80 + 32'(len), "R6 R10 pointer advanced", v, 32'h80 + 32'(len));
                rd_reg(0, v);
                check(v == 32'(len % 2), "R6 R7 status after chain end", v, 32'(len % 2));
                rd_reg(0, v);
                check(v == 0, "R7 status read clears irq", v, 0);
            end
        end

        // three-descriptor chain with a zero-length middle entry (R1 R9)
        lat = 1; rdy_mode = 0; cap_n = 0; rd_n = 0;
        for (int i = 0; i < 8; i++) begin mem[256 + i] = pat(256 + i); mem[320 + i] = pat(320 + i); end
        pw(16, 32'h100); pw(20, 32'd3);                 pw(24, 32'h20);
        pw(32, 32'h180); pw(36, IRQ);                   pw(40, 32'h30);
        pw(48, 32'h140); pw(52, EOC | EOP | 32'd4);     pw(56, 32'h3C0);
        wr_reg(1, 32'h10);
        wr_reg(0, GO_TX);
        repeat (400) @(negedge clk);
        ok = (rd_n == 9);
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < 3; w++)
                if (rd_log[k*3+w] != 32'(16 + 16*k + 4*w)) ok = 0;
        check(ok, "R1 descriptor word fetch order", 32'(rd_n), 9);
        ok = (cap_n == 7);
        for (int i = 0; i < 7 && i < cap_n; i++) begin
            if (cap_d[i] != ((i < 3) ? pat(256 + i) : pat(320 + i - 3))) ok = 0;
            if (cap_l[i] != (i == 6)) ok = 0;
        end
        check(ok, "R9 zero-length entry moves no data", 32'(cap_n), 7);
        check(rw(36) == (IRQ | DON), "R9 zero-length write-back", rw(36), IRQ | DON);
        check(irq == 1, "R9 zero-length irq honoured", {31'h0, irq}, 1);
        rd_reg(1, v);
        check(v == 32'h3C0, "R6 pointer at end of chain", v, 32'h3C0);
        rd_reg(0, v);

        // receive chain (R2 R4 R5)
        for (int i = 512; i < 560; i++) mem[i] = 8'h55;
        lat = 2; rx_idx = 0; rx_total = 7;
        pw(80, 32'h200); pw(84, OWN | 32'd4);             pw(88, 32'h60);
        pw(96, 32'h210); pw(100, OWN | EOC | IRQ | 32'd3); pw(104, 32'h0);
        wr_reg(1, 32'h50);
        wr_reg(0, GO_RX);
        repeat (400) @(negedge clk);
        ok = 1;
        for (int i = 0; i < 4; i++) if (mem[512 + i] != 8'(8'hA0 + i)) ok = 0;
        for (int i = 0; i < 3; i++) if (mem[528 + i] != 8'(8'hA4 + i)) ok = 0;
        check(ok, "R4 received bytes stored", {24'h0, mem[512]}, 32'hA0);
        check(mem[516] == 8'h55 && mem[531] == 8'h55, "R2 byte past count untouched", {24'h0, mem[516]}, 32'h55);
        check(rw(84) == 32'd4 && rw(100) == (EOC | IRQ | 32'd3), "R5 receive write-back clears owned", rw(100), EOC | IRQ | 32'd3);
        check(irq == 1, "R7 receive irq", {31'h0, irq}, 1);
        rd_reg(0, v);

        // descriptor not owned (R4)
        rx_idx = 0; rx_total = 2;
        pw(112, 32'h220); pw(116, EOC | IRQ | 32'd2); pw(120, 32'h0);
        wr_reg(1, 32'h70);
        wr_reg(0, GO_RX);
        repeat (200) @(negedge clk);
        check(mem[544] == 8'h55 && mem[545] == 8'h55, "R4 unowned buffer untouched", {24'h0, mem[544]}, 32'h55);
        check(rw(116) == (EOC | IRQ | 32'd2), "R4 unowned control word kept", rw(116), EOC | IRQ | 32'd2);
        rd_reg(0, v);
        check(v == 0, "R4 halted without irq", v, 0);
        rd_reg(1, v);
        check(v == 32'h70, "R4 pointer stays on unowned entry", v, 32'h70);
        rx_total = 0; rx_idx = 0;

        // pointer write while running, then abort (R8 R10)
        lat = 0; rdy_mode = 2; cap_n = 0;
        pw(64, 32'h100); pw(68, EOC | 32'd5); pw(72, 32'h0);
        wr_reg(1, 32'h40);
        wr_reg(0, GO_TX);
        repeat (30) @(negedge clk);
        wr_reg(1, 32'h300);
        rd_reg(1, v);
        check(v == 32'h40, "R10 pointer write ignored while running", v, 32'h40);
        rd_reg(0, v);
        check(v == 2, "R8 busy flag while running", v, 2);
        wr_reg(0, 32'h20);
        rd_reg(0, v);
        check(v == 0, "R8 load-enable with start clear stops", v, 0);
        rdy_mode = 0;
        repeat (50) @(negedge clk);
        check(cap_n == 0 && rw(68) == (EOC | 32'd5), "R8 stopped channel moves nothing", 32'(cap_n), 0);

        // completion and status read in the same cycle (R7)
        cap_n = 0; lat = 1;
        pw(64, 32'h100); pw(68, EOC | IRQ | 32'd2); pw(72, 32'h0);
        wr_reg(1, 32'h40);
        wr_reg(0, GO_TX);
        seen = 0; seen_rd = 0;
        @(negedge clk); reg_rd = 1; reg_sel = 0;
        repeat (300) begin
            @(negedge clk); #1;
            if (irq) seen++;
            if (reg_rdata[0]) seen_rd++;
        end
        reg_rd = 0;
        check(seen == 1 && seen_rd == 1, "R7 set wins over simultaneous read", 32'(seen), 1);
        check(cap_n == 2, "R7 collision run completed", 32'(cap_n), 2);

        summary();
        $finish;
    end
endmodule